// File: doc/BRIEF.md
# Shadow-Backed Configuration and Address Decode for a Nonvolatile Memory Module

This block is the bus-facing front end of an on-chip nonvolatile memory module. It keeps two live control registers: a configuration word with stop, lock and boot-response bits, and an array base page. Each live register has a nonvolatile shadow copy. Shadow copies are written through a separate program/erase strobe interface. Programming can only clear bits, and an erase sets every shadow bit to one. A shadow never changes the live value directly. The live registers pick up their shadows only on the load cycle, which is the first clock edge after reset is released. On that same edge a strap pin is sampled, and its value can wake the array out of its stopped state.

Every bus access is steered to one of three places, or to none. The bootstrap vector area is the eight bytes at address zero. The module's 16-byte register block sits at a fixed base. The array window is a 4 KB page chosen by the base register. The block answers with a one-cycle acknowledge and a hit flag that names the target. For reads of its own registers it also returns the register data.

Top module: `nvm_frontend`

## Requirements
- R1: On the load cycle each live register takes its shadow value. Stop becomes 1 unless the stop shadow bit is 0 and strap_i is 1 on that edge. The configuration register keeps stop in bit 15, lock in bit 14 and boot in bit 13; all its other bits read 0. The register block holds the configuration register at offset 0 and the base register at offset 2. The base register keeps the array page (address bits 19:12) in bits 7:0 and its upper bits read 0.
- R2: A shadow program request at register select 0 (configuration) or 1 (base) changes that shadow to old AND data. It leaves the live registers unchanged until the next load cycle.
- R3: An erase request sets every shadow bit to 1. The live registers are not changed by it.
- R4: Bus writes to the control registers change only the live registers and never any shadow.
- R5: A write to the base register is ignored while lock is 1 and stop is 0. It is accepted while lock is 0 or stop is 1.
- R6: Once lock is 1, a configuration write cannot clear it. Only the load cycle can give lock a new value.
- R7: When the module is not stopped, an access whose address bits 19:12 equal the base page is an array hit. If stop is set, such an access gets no acknowledge.
- R8: Any access inside the 16-byte register block is a register hit, including when the array window covers that block. Offsets with no register read 0, and writes to them have no effect.
- R9: While boot is 0 and stop is 0, an access to bytes 0 to 7 is a boot hit. This check comes before every other decode. Otherwise those bytes are decoded as any other address.
- R10: Each access gets its response on the cycle after it is presented: ack_o and at most one hit flag, all for one cycle. An access that hits nothing gets no acknowledge, and rdata_o is 0 on every cycle except a register read response.
- R11: An access presented on the load cycle is not answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_i | input | 1 | Strap pin, sampled on the load cycle |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 20 | Byte address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Register read data, 0 otherwise |
| ack_o | output | 1 | One-cycle acknowledge |
| reg_hit_o | output | 1 | Response is for the register block |
| arr_hit_o | output | 1 | Response is for the array window |
| boot_hit_o | output | 1 | Response is for the bootstrap vector area |
| sh_prog_i | input | 1 | Shadow program request |
| sh_erase_i | input | 1 | Shadow erase request |
| sh_sel_i | input | 1 | Shadow select: 0 configuration, 1 base |
| sh_data_i | input | 16 | Shadow program data |

## Verification
The hardest case to reach is a shadow value that differs from its live register, because only a reset shows what the shadow holds. The stimulus therefore mixes random shadow programs and erases with random bus writes, and at random points applies a reset with a random strap. After each reset it reads the registers back, so that any leak between the shadow and live paths shows up on the next load. A directed sequence covers the other corners. It moves the base page over the register block. It sets lock, and then tries base writes with stop clear and with stop set. It starts from a shadow with stop clear, once with the strap low and once with it high.

// File: rtl/nvm_fe_pkg.sv
package nvm_fe_pkg;
  typedef enum logic [1:0] {HIT_NONE, HIT_REG, HIT_ARR, HIT_BOOT} hit_e;
  localparam int NREG     = 2;
  localparam int IX_CFG   = 0;
  localparam int IX_BASE  = 1;
  localparam int STOP_BIT = 15;
  localparam int LOCK_BIT = 14;
  localparam int BOOT_BIT = 13;
  localparam int PAGE_W   = 12;
  localparam int BOOT_AW  = 3;
endpackage

// File: rtl/nvm_shadow_store.sv
module nvm_shadow_store #(
  parameter int DW   = 16,
  parameter int NREG = 2,
  parameter int SELW = 1
) (
  input  logic                      clk_i,
  input  logic                      prog_i,
  input  logic                      erase_i,
  input  logic [SELW-1:0]           sel_i,
  input  logic [DW-1:0]             data_i,
  output logic [NREG-1:0][DW-1:0]   shadow_o
);
  // nonvolatile: no reset, erase fills ones, program only clears
  for (genvar g = 0; g < NREG; g++) begin : g_cell
    logic [DW-1:0] cell_q;
    always_ff @(posedge clk_i) begin
      if (erase_i)
        cell_q <= '1;
      else if (prog_i && sel_i == SELW'(g))
        cell_q <= cell_q & data_i;
    end
    assign shadow_o[g] = cell_q;
  end
endmodule

// File: rtl/nvm_ctrl_regs.sv
module nvm_ctrl_regs import nvm_fe_pkg::*; #(
  parameter int DW  = 16,
  parameter int ABW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           strap_i,
  input  logic [DW-1:0]  sh_cfg_i,
  input  logic [DW-1:0]  sh_base_i,
  input  logic           wr_cfg_i,
  input  logic           wr_base_i,
  input  logic [DW-1:0]  wdata_i,
  output logic           stop_o,
  output logic           lock_o,
  output logic           boot_o,
  output logic [ABW-1:0] base_o
);
  logic base_we;
  logic unused_bits;

  assign base_we     = !lock_o || stop_o;
  assign unused_bits = ^{sh_cfg_i, sh_base_i, wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_o <= 1'b1;
      lock_o <= 1'b1;
      boot_o <= 1'b1;
      base_o <= '1;
    end else if (load_i) begin
      stop_o <= sh_cfg_i[STOP_BIT] | ~strap_i;
      lock_o <= sh_cfg_i[LOCK_BIT];
      boot_o <= sh_cfg_i[BOOT_BIT];
      base_o <= sh_base_i[ABW-1:0];
    end else begin
      if (wr_cfg_i) begin
        stop_o <= wdata_i[STOP_BIT];
        lock_o <= lock_o | wdata_i[LOCK_BIT];
        boot_o <= wdata_i[BOOT_BIT];
      end
      if (wr_base_i && base_we)
        base_o <= wdata_i[ABW-1:0];
    end
  end
endmodule

// File: rtl/nvm_addr_decode.sv
module nvm_addr_decode import nvm_fe_pkg::*; #(
  parameter int              AW       = 20,
  parameter int              ABW      = 8,
  parameter int              REG_AW   = 4,
  parameter logic [AW-1:0]   REG_BASE = 20'h7F000
) (
  input  logic [AW-1:0]     addr_i,
  input  logic              stop_i,
  input  logic              boot_i,
  input  logic [ABW-1:0]    base_i,
  output hit_e              hit_o,
  output logic [REG_AW-2:0] reg_ix_o
);
  logic boot_area, reg_area, arr_area, boot_en;
  logic unused_lsb;

  assign unused_lsb = addr_i[0];
  assign boot_en    = !boot_i && !stop_i;
  assign boot_area  = addr_i[AW-1:BOOT_AW] == '0;
  assign reg_area   = addr_i[AW-1:REG_AW] == REG_BASE[AW-1:REG_AW];
  assign arr_area   = !stop_i && (addr_i[AW-1:AW-ABW] == base_i);
  assign reg_ix_o   = addr_i[REG_AW-1:1];

  // priority: boot vectors, own registers, array window
  always_comb begin
    if (boot_en && boot_area) hit_o = HIT_BOOT;
    else if (reg_area)        hit_o = HIT_REG;
    else if (arr_area)        hit_o = HIT_ARR;
    else                      hit_o = HIT_NONE;
  end
endmodule

// File: rtl/nvm_frontend.sv
module nvm_frontend import nvm_fe_pkg::*; #(
  parameter int                  ADDR_W   = 20,
  parameter int                  DATA_W   = 16,
  parameter int                  REG_AW   = 4,
  parameter logic [ADDR_W-1:0]   REG_BASE = 20'h7F000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o,
  output logic              reg_hit_o,
  output logic              arr_hit_o,
  output logic              boot_hit_o,
  input  logic              sh_prog_i,
  input  logic              sh_erase_i,
  input  logic              sh_sel_i,
  input  logic [DATA_W-1:0] sh_data_i
);
  localparam int ABW  = ADDR_W - PAGE_W;
  localparam int SELW = 1;
  localparam int IXW  = REG_AW - 1;

  logic                          ready_q, load, access;
  logic [NREG-1:0][DATA_W-1:0]   sh_q;
  logic                          stop, lock, boot;
  logic [ABW-1:0]                base;
  hit_e                          hit;
  logic [IXW-1:0]                reg_ix;
  logic                          wr_cfg, wr_base;
  logic [DATA_W-1:0]             rd_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= 1'b1;
  end

  assign load   = !ready_q;
  assign access = ready_q && (rd_i || wr_i);

  nvm_shadow_store #(.DW(DATA_W), .NREG(NREG), .SELW(SELW)) u_shadow (
    .clk_i    (clk_i),
    .prog_i   (sh_prog_i),
    .erase_i  (sh_erase_i),
    .sel_i    (sh_sel_i),
    .data_i   (sh_data_i),
    .shadow_o (sh_q)
  );

  nvm_addr_decode #(.AW(ADDR_W), .ABW(ABW), .REG_AW(REG_AW), .REG_BASE(REG_BASE)) u_dec (
    .addr_i   (addr_i),
    .stop_i   (stop),
    .boot_i   (boot),
    .base_i   (base),
    .hit_o    (hit),
    .reg_ix_o (reg_ix)
  );

  assign wr_cfg  = access && wr_i && hit == HIT_REG && reg_ix == IXW'(IX_CFG);
  assign wr_base = access && wr_i && hit == HIT_REG && reg_ix == IXW'(IX_BASE);

  nvm_ctrl_regs #(.DW(DATA_W), .ABW(ABW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .strap_i   (strap_i),
    .sh_cfg_i  (sh_q[IX_CFG]),
    .sh_base_i (sh_q[IX_BASE]),
    .wr_cfg_i  (wr_cfg),
    .wr_base_i (wr_base),
    .wdata_i   (wdata_i),
    .stop_o    (stop),
    .lock_o    (lock),
    .boot_o    (boot),
    .base_o    (base)
  );

  always_comb begin
    rd_val = '0;
    if (reg_ix == IXW'(IX_CFG)) begin
      rd_val[STOP_BIT] = stop;
      rd_val[LOCK_BIT] = lock;
      rd_val[BOOT_BIT] = boot;
    end else if (reg_ix == IXW'(IX_BASE)) begin
      rd_val[ABW-1:0] = base;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o      <= 1'b0;
      reg_hit_o  <= 1'b0;
      arr_hit_o  <= 1'b0;
      boot_hit_o <= 1'b0;
      rdata_o    <= '0;
    end else begin
      ack_o      <= access && hit != HIT_NONE;
      reg_hit_o  <= access && hit == HIT_REG;
      arr_hit_o  <= access && hit == HIT_ARR;
      boot_hit_o <= access && hit == HIT_BOOT;
      rdata_o    <= (access && rd_i && !wr_i && hit == HIT_REG) ? rd_val : '0;
    end
  end
endmodule

// File: rtl/nvm_frontend_chk.sv
module nvm_frontend_chk #(
  parameter int DW   = 16,
  parameter int NREG = 2,
  parameter int ABW  = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    ready_q,
  input logic                    wr_i,
  input logic                    sh_prog_i,
  input logic                    sh_erase_i,
  input logic                    wr_base,
  input logic                    stop,
  input logic                    lock,
  input logic                    boot,
  input logic [ABW-1:0]          base,
  input logic [NREG-1:0][DW-1:0] sh_q,
  input logic                    ack_o,
  input logic                    reg_hit_o,
  input logic                    arr_hit_o,
  input logic                    boot_hit_o
);
  a_r2_prog_keeps_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q && sh_prog_i && !wr_i |=> $stable({stop, lock, boot, base}));

  a_r3_erase_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_erase_i |=> (&sh_q));

  a_r4_shadow_only_by_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q && !sh_prog_i && !sh_erase_i |=> $stable(sh_q));

  a_r5_locked_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q && wr_base && lock && !stop |=> $stable(base));

  a_r6_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q && lock |=> lock);

  a_r7_stop_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q && stop |=> !arr_hit_o && !boot_hit_o);

  a_r10_one_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_hit_o, arr_hit_o, boot_hit_o}));

  a_r11_no_ack_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_q |=> !ack_o);
endmodule

bind nvm_frontend nvm_frontend_chk #(.DW(DATA_W), .NREG(nvm_fe_pkg::NREG), .ABW(ABW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ready_q    (ready_q),
  .wr_i       (wr_i),
  .sh_prog_i  (sh_prog_i),
  .sh_erase_i (sh_erase_i),
  .wr_base    (wr_base),
  .stop       (stop),
  .lock       (lock),
  .boot       (boot),
  .base       (base),
  .sh_q       (sh_q),
  .ack_o      (ack_o),
  .reg_hit_o  (reg_hit_o),
  .arr_hit_o  (arr_hit_o),
  .boot_hit_o (boot_hit_o)
);

// File: tb/tb_nvm_frontend.sv
`timescale 1ns/1ps
module tb_nvm_frontend;
  localparam logic [19:0] REG_ADDR = 20'h7F000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strap_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [19:0] addr_i = '0;
  logic [15:0] wdata_i = '0, sh_data_i = '0;
  logic        sh_prog_i = 1'b0, sh_erase_i = 1'b0, sh_sel_i = 1'b0;
  logic [15:0] rdata_o;
  logic        ack_o, reg_hit_o, arr_hit_o, boot_hit_o;

  int nchk = 0, nerr = 0;
  bit done = 0;

  // reference model
  bit          m_stop, m_lock, m_boot;
  logic [7:0]  m_base;
  logic [15:0] m_sh [2];

  always #5 clk = ~clk;

  nvm_frontend dut (
    .clk_i(clk), .rst_ni(rst_ni), .strap_i(strap_i), .rd_i(rd_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_o(ack_o),
    .reg_hit_o(reg_hit_o), .arr_hit_o(arr_hit_o), .boot_hit_o(boot_hit_o),
    .sh_prog_i(sh_prog_i), .sh_erase_i(sh_erase_i), .sh_sel_i(sh_sel_i),
    .sh_data_i(sh_data_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 0 none, 1 register, 2 array, 3 boot
  function automatic int exp_kind(input logic [19:0] a);
    if (a[19:3] == '0 && !m_boot && !m_stop) return 3;
    if (a[19:4] == REG_ADDR[19:4])           return 1;
    if (!m_stop && a[19:12] == m_base)       return 2;
    return 0;
  endfunction

  function automatic logic [15:0] exp_reg(input logic [19:0] a);
    case (a[3:1])
      3'd0:    return {m_stop, m_lock, m_boot, 13'b0};
      3'd1:    return {8'b0, m_base};
      default: return 16'h0;
    endcase
  endfunction

  task automatic acc(input bit rd, input bit wr, input logic [19:0] a,
                     input logic [15:0] wd, input string req);
    int k;
    logic [15:0] er;
    k  = exp_kind(a);
    er = (rd && k == 1) ? exp_reg(a) : 16'h0;
    @(negedge clk);
    rd_i = rd; wr_i = wr; addr_i = a; wdata_i = wd;
    @(negedge clk);
    rd_i = 0; wr_i = 0;
    chk(req, {ack_o, reg_hit_o, arr_hit_o, boot_hit_o},
        {k != 0, k == 1, k == 2, k == 3});
    chk(req, rdata_o, er);
    if (wr && k == 1) begin
      if (a[3:1] == 3'd0) begin
        m_stop = wd[15]; m_lock = m_lock | wd[14]; m_boot = wd[13];
      end else if (a[3:1] == 3'd1 && (!m_lock || m_stop)) begin
        m_base = wd[7:0];
      end
    end
  endtask

  task automatic sh_prog(input bit sel, input logic [15:0] d);
    @(negedge clk);
    sh_prog_i = 1; sh_sel_i = sel; sh_data_i = d;
    @(negedge clk);
    sh_prog_i = 0;
    m_sh[sel] = m_sh[sel] & d;
  endtask

  task automatic sh_erase();
    @(negedge clk);
    sh_erase_i = 1;
    @(negedge clk);
    sh_erase_i = 0;
    m_sh[0] = '1; m_sh[1] = '1;
  endtask

  task automatic do_reset(input bit strap, input bit erase);
    @(negedge clk);
    rst_ni = 0;
    @(negedge clk);
    chk("R10", {ack_o, reg_hit_o, arr_hit_o, boot_hit_o, rdata_o}, '0);
    if (erase) sh_erase();
    @(negedge clk);
    strap_i = strap; rd_i = 1; addr_i = REG_ADDR; rst_ni = 1;
    @(negedge clk);
    rd_i = 0; strap_i = ~strap;
    chk("R11", {ack_o, reg_hit_o, rdata_o}, '0);
    m_stop = m_sh[0][15] | ~strap;
    m_lock = m_sh[0][14];
    m_boot = m_sh[0][13];
    m_base = m_sh[1][7:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL R10: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: erased shadows give stop, lock, boot set and an all-ones page
    do_reset(1'b1, 1'b1);
    acc(1, 0, REG_ADDR,       16'h0, "R1");
    acc(1, 0, REG_ADDR + 2,   16'h0, "R1");
    chk("R1", {m_stop, m_lock, m_boot, m_base}, {3'b111, 8'hFF});

    // R2: program clears bits but live values wait for reset
    sh_prog(1'b0, 16'h1FFF);
    acc(1, 0, REG_ADDR, 16'h0, "R2");
    sh_prog(1'b1, 16'h0012);
    acc(1, 0, REG_ADDR + 2, 16'h0, "R2");
    do_reset(1'b1, 1'b0);
    acc(1, 0, REG_ADDR,     16'h0, "R1");
    acc(1, 0, REG_ADDR + 2, 16'h0, "R2");
    chk("R2", {m_stop, m_lock, m_boot, m_base}, {3'b000, 8'h12});

    // decode paths
    acc(1, 0, 20'h12344, 16'h0, "R7");
    acc(0, 1, 20'h12FFE, 16'hBEEF, "R7");
    acc(1, 0, 20'h00004, 16'h0, "R9");
    acc(1, 0, 20'h30000, 16'h0, "R10");
    acc(0, 1, 20'h30002, 16'h1234, "R10");

    // R8: base page placed over the register block
    acc(0, 1, REG_ADDR + 2, 16'h007F, "R5");
    acc(1, 0, REG_ADDR + 2, 16'h0, "R8");
    acc(1, 0, REG_ADDR + 4, 16'h0, "R8");
    acc(0, 1, REG_ADDR + 6, 16'hFFFF, "R8");
    acc(1, 0, REG_ADDR,     16'h0, "R8");
    acc(1, 0, 20'h7F800,    16'h0, "R8");
    acc(1, 0, 20'h7F010,    16'h0, "R8");

    // R5/R6: lock protection and stickiness
    acc(0, 1, REG_ADDR,     16'h4000, "R6");
    acc(0, 1, REG_ADDR + 2, 16'h0033, "R5");
    acc(1, 0, REG_ADDR + 2, 16'h0, "R5");
    acc(0, 1, REG_ADDR,     16'h0000, "R6");
    acc(1, 0, REG_ADDR,     16'h0, "R6");
    acc(0, 1, REG_ADDR,     16'hC000, "R6");
    acc(0, 1, REG_ADDR + 2, 16'h0033, "R5");
    acc(1, 0, REG_ADDR + 2, 16'h0, "R5");
    acc(1, 0, 20'h00000,    16'h0, "R9");
    acc(1, 0, 20'h33000,    16'h0, "R7");

    // R4: live writes vanish at reset, shadow decides
    acc(0, 1, REG_ADDR, 16'h2000, "R4");
    do_reset(1'b1, 1'b0);
    acc(1, 0, REG_ADDR,     16'h0, "R4");
    acc(1, 0, REG_ADDR + 2, 16'h0, "R4");
    acc(1, 0, 20'h00006,    16'h0, "R9");

    // R3: erase leaves live registers, next reset shows the erased state
    sh_erase();
    acc(1, 0, REG_ADDR,     16'h0, "R3");
    acc(1, 0, REG_ADDR + 2, 16'h0, "R3");
    do_reset(1'b1, 1'b0);
    acc(1, 0, REG_ADDR, 16'h0, "R3");

    // R1: strap low keeps the array stopped
    sh_prog(1'b0, 16'h1FFF);
    do_reset(1'b0, 1'b0);
    acc(1, 0, REG_ADDR, 16'h0, "R1");
    acc(1, 0, 20'h00002, 16'h0, "R9");
    acc(1, 0, 20'hFF100, 16'h0, "R7");

    // constrained random mix
    for (int i = 0; i < 800; i++) begin
      int unsigned r;
      r = $urandom % 100;
      if (r < 3) begin
        do_reset(1'(($urandom % 4) != 0), 1'b0);
        acc(1, 0, REG_ADDR, 16'h0, "R1");
      end else if (r < 7) begin
        sh_prog(1'($urandom % 2), 16'($urandom) | 16'h1F00);
      end else if (r < 8) begin
        sh_erase();
        sh_prog(1'b0, 16'h1FFF);
      end else begin
        logic [19:0] a;
        bit rd;
        string tag;
        case ($urandom % 5)
          0:       a = {17'b0, 2'($urandom), 1'b0};
          1:       a = {REG_ADDR[19:4], 3'($urandom % 3), 1'b0};
          2:       a = {m_base, 11'($urandom), 1'b0};
          3:       a = {8'h7F, 11'($urandom), 1'b0};
          default: a = {19'($urandom), 1'b0};
        endcase
        rd = 1'($urandom % 2);
        case (exp_kind(a))
          1:       tag = "R8";
          2:       tag = "R7";
          3:       tag = "R9";
          default: tag = "R10";
        endcase
        acc(rd, !rd, a, 16'($urandom) & 16'hA0FF, tag);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule